// File: doc/BRIEF.md
# Last-In-First-Out Word Stack with In-Place Replace

This block is a synchronous LIFO store of 32 words of 16 bits, held in a two-port RAM written so that an FPGA block RAM can be inferred. A push writes the input word as the new top. A pop discards the top. Raising push and pop in the same cycle overwrites the current top with the input word and leaves the depth as it is, which lets a stack machine fold a "drop then push" into one cycle.

Internally two address pointers move in lockstep as the stack grows toward lower addresses. The write pointer names the next free slot and the read pointer names the current top. A depth counter drives the full and empty flags. The top-of-stack output is a register that holds the word at the top after every clock edge, with a bypass for the word written on that same edge. Requests that cannot be served are dropped without side effects.

Top module: `lifo_replace_stack`

## Requirements
- R1: The stack holds up to 32 entries of 16 bits each, and all 32 can be stored and read back.
- R2: While clr is high at a rising edge, the stack is emptied: after that edge empty=1, full=0, q=0. clr takes priority over push and pop.
- R3: A push alone (push=1, pop=0) while not full stores d as the new top, and after that same edge q equals d and the depth is one higher.
- R4: A pop alone (pop=1, push=0) while not empty removes the top, and after that edge q shows the entry that was beneath it, or 0 if the stack is now empty.
- R5: push=1 with pop=1 while not empty overwrites the top with d: after that edge q equals d, and the depth and the flags are unchanged.
- R6: full=1 exactly when 32 entries are held, empty=1 exactly when none are held, and the two flags are never high together. Both are registered and change on the same edge as q.
- R7: A push alone while full is ignored: q, the flags and every stored entry stay as they were.
- R8: A pop alone, or push with pop, while empty is ignored: the stack stays empty and q stays 0.
- R9: Entries leave in the reverse order of entry. Internally the read pointer always equals the write pointer plus one, modulo 32. A push moves both pointers down by one and a pop moves both up by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr | input | 1 | Synchronous active-high clear |
| d | input | 16 | Word to push or to replace the top with |
| push | input | 1 | Push request |
| pop | input | 1 | Pop request; with push, requests a replace |
| q | output | 16 | Registered current top of stack (0 when empty) |
| full | output | 1 | Registered flag, high when 32 entries are held |
| empty | output | 1 | Registered flag, high when no entry is held |

## Verification
Every result of this block is due on the first rising edge after the request is presented: q, full and empty all reflect a push, pop, replace or clear right after that single edge, with no extra read latency. The bench therefore changes inputs on the falling edge, lets one rising edge pass, and compares all three outputs one time unit later against a reference array and depth kept in the bench. The sweep fills the stack to capacity, overdrives it, replaces at the full boundary, drains it to empty and underdrives it, clears it mid-run, and then runs a long pseudo-random mix of all four request combinations.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_PUSH    = 2'd1,
    OP_POP     = 2'd2,
    OP_REPLACE = 2'd3
  } stack_op_e;
endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
  import lifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW-1:0] rd_next,
  output logic          next_empty,
  output logic          full,
  output logic          empty
);
  localparam int CW = $clog2(DEPTH + 1);

  stack_op_e     op;
  logic [AW-1:0] wr_ptr, rd_ptr, wr_n, rd_n;
  logic [CW-1:0] cnt, cnt_n;

  // Requests that cannot be served collapse to idle.
  always_comb begin
    op = OP_IDLE;
    if (push && pop) begin
      if (!empty) op = OP_REPLACE;
    end else if (push) begin
      if (!full) op = OP_PUSH;
    end else if (pop) begin
      if (!empty) op = OP_POP;
    end
  end

  always_comb begin
    wr_n  = wr_ptr;
    rd_n  = rd_ptr;
    cnt_n = cnt;
    case (op)
      OP_PUSH: begin
        wr_n  = wr_ptr - AW'(1);
        rd_n  = rd_ptr - AW'(1);
        cnt_n = cnt + CW'(1);
      end
      OP_POP: begin
        wr_n  = wr_ptr + AW'(1);
        rd_n  = rd_ptr + AW'(1);
        cnt_n = cnt - CW'(1);
      end
      default: ;
    endcase
  end

  assign mem_we     = (op == OP_PUSH) || (op == OP_REPLACE);
  assign mem_waddr  = (op == OP_PUSH) ? wr_ptr : rd_ptr;
  assign rd_next    = rd_n;
  assign next_empty = (cnt_n == '0);

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_ptr <= AW'(DEPTH - 1);
      rd_ptr <= '0;
      cnt    <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      wr_ptr <= wr_n;
      rd_ptr <= rd_n;
      cnt    <= cnt_n;
      full   <= (cnt_n == CW'(DEPTH));
      empty  <= (cnt_n == '0);
    end
  end

  a_r9_rd_tracks_wr: assert property (@(posedge clk) disable iff (clr)
    rd_ptr == AW'(wr_ptr + AW'(1)));

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (clr)
    !(full && empty));

  a_r3_push_grows: assert property (@(posedge clk) disable iff (clr)
    (push && !pop && !full) |=> (cnt == CW'($past(cnt) + CW'(1))));

  a_r5_replace_keeps_depth: assert property (@(posedge clk) disable iff (clr)
    (push && pop && !empty) |=> $stable(cnt));

  a_r7_full_push_ignored: assert property (@(posedge clk) disable iff (clr)
    (push && !pop && full) |=> (full && $stable(wr_ptr)));

  a_r8_empty_pop_ignored: assert property (@(posedge clk) disable iff (clr)
    (pop && empty) |=> (empty && $stable(rd_ptr)));
endmodule

// File: rtl/lifo_mem.sv
module lifo_mem #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  input  logic             zero_out,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Write port: no reset so the array maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read of the next top, bypassing the word written this edge.
  always_ff @(posedge clk) begin
    if (clr || zero_out)             q <= '0;
    else if (we && (waddr == raddr)) q <= wdata;
    else                             q <= mem[raddr];
  end
endmodule

// File: rtl/lifo_replace_stack.sv
module lifo_replace_stack #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] d,
  input  logic             push,
  input  logic             pop,
  output logic [WIDTH-1:0] q,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [AW-1:0] rd_next;
  logic          next_empty;

  lifo_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk       (clk),
    .clr       (clr),
    .push      (push),
    .pop       (pop),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .rd_next   (rd_next),
    .next_empty(next_empty),
    .full      (full),
    .empty     (empty)
  );

  lifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_mem (
    .clk     (clk),
    .clr     (clr),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (d),
    .raddr   (rd_next),
    .zero_out(next_empty),
    .q       (q)
  );

  a_r3_q_shows_pushed: assert property (@(posedge clk) disable iff (clr)
    (push && !full && !empty) |=> (q == $past(d)));

  a_r8_empty_q_zero: assert property (@(posedge clk) disable iff (clr)
    (pop && empty) |=> (q == '0));
endmodule

// File: tb/lifo_replace_stack_bench.sv
module lifo_replace_stack_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int WIDTH = 16;

  logic             clk = 1'b0;
  logic             clr = 1'b1;
  logic [WIDTH-1:0] d = '0;
  logic             push = 1'b0;
  logic             pop = 1'b0;
  logic [WIDTH-1:0] q;
  logic             full, empty;

  int errors = 0;
  int checks = 0;

  logic [WIDTH-1:0] model [DEPTH];
  int               depth = 0;
  logic [15:0]      lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  lifo_replace_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_lifo_replace_stack (
    .clk(clk), .clr(clr), .d(d), .push(push), .pop(pop),
    .q(q), .full(full), .empty(empty)
  );

  task automatic step(input logic c, input logic p, input logic o,
                      input logic [WIDTH-1:0] v, input string tag);
    logic [WIDTH-1:0] eq;
    @(negedge clk);
    clr = c; push = p; pop = o; d = v;
    @(posedge clk);
    #1;
    if (c) depth = 0;
    else if (p && !o) begin
      if (depth < DEPTH) begin model[depth] = v; depth++; end
    end else if (o && !p) begin
      if (depth > 0) depth--;
    end else if (p && o) begin
      if (depth > 0) model[depth-1] = v;
    end
    eq = (depth == 0) ? '0 : model[depth-1];
    checks++;
    if (q !== eq || full !== (depth == DEPTH) || empty !== (depth == 0)) begin
      errors++;
      $display("FAIL %s: q=%h full=%b empty=%b expected q=%h full=%b empty=%b",
               tag, q, full, empty, eq, depth == DEPTH, depth == 0);
    end
  endtask

  function automatic logic [WIDTH-1:0] pat(input int i);
    return WIDTH'(16'hA000 ^ (i * 37) ^ (i << 9));
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(1, 0, 0, '0, "R2 reset");
    step(1, 1, 1, 16'h1234, "R2 reset priority");
    step(0, 0, 1, '0, "R8 pop on empty");
    step(0, 1, 1, 16'hBEEF, "R8 replace on empty");
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, pat(i), "R1 R3 R6 fill");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 16'hDEAD, "R7 push while full");
    step(0, 0, 0, '0, "R6 idle at full");
    step(0, 1, 1, 16'h5A5A, "R5 replace at full");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, '0, "R4 R9 drain order");
    step(0, 0, 1, '0, "R8 pop after drain");
    step(0, 1, 1, 16'h7777, "R8 replace after drain");
    for (int i = 0; i < 5; i++) step(0, 1, 0, pat(i + 100), "R3 refill");
    step(0, 1, 1, 16'h0F0F, "R5 replace mid");
    step(1, 1, 0, 16'h1111, "R2 clear mid-run");
    step(0, 0, 0, '0, "R6 idle empty");
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] sel;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sel = lfsr[1:0];
      if (i % 1000 < 500) begin
        if (sel == 2'd2) step(0, 0, 1, lfsr, "R4 R9 mixed");
        else if (sel == 2'd3) step(0, 1, 1, lfsr, "R5 mixed");
        else step(0, 1, 0, lfsr, "R3 R7 mixed");
      end else begin
        if (sel == 2'd1) step(0, 1, 0, lfsr, "R3 mixed");
        else if (sel == 2'd3) step(0, 1, 1, lfsr, "R5 R8 mixed");
        else step(0, 0, 1, lfsr, "R4 R8 mixed");
      end
    end
    step(1, 0, 0, '0, "R2 final clear");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule